// File: doc/BRIEF.md
# Pad Function Multiplexer with Level Wake Detection

This block holds the digital side of one I/O pad. A 32-bit configuration word, written and read over a simple register port, selects which of up to 63 peripheral functions owns the pad. A connect bit gates the chosen output and its output enable. The configuration also controls data inversion in both directions and an open-drain mode, in which a logic high releases the pad instead of driving it. Five bits drive the pad's pull-up, pull-down, input-enable, hysteresis and drive-strength controls directly.

The pad input passes through a two-flop synchronizer. An input-enable bit can force it to zero. The result feeds the peripherals, after the optional inversion, and a level comparator. When wake is enabled and the synchronized level equals the programmed compare value, the block raises a registered wake request and sets a sticky status bit. Software reads that status bit in the configuration word. Disabling wake or pulsing a clear strobe resets it.

Top module: `iopad_cell`

## Requirements
- R1: After reset, the configuration reads 0, and `pad_out`, `pad_oe`, `per_din` and `wake_req` are 0.
- R2: Only bits 28..25, 20..16, 7 and 5..0 are writable. Reserved bits always read 0. Writes to bit 13 (wake status) have no effect. Writing all ones reads back 0x1E1F00BF while no wake is pending.
- R3: With bit 7 = 1 and select value k in bits 5..0 (1..63), `pad_out` follows bit k-1 of `per_dout` and `pad_oe` follows bit k-1 of `per_oe`. A select of 0 gives `pad_out` = 0 and `pad_oe` = 0.
- R4: With bit 7 = 0, `pad_out` and `pad_oe` are 0 whatever the peripheral inputs are.
- R5: With bit 26 = 1, `pad_out` is the complement of the selected peripheral data, and `per_din` is the complement of the synchronized pad level.
- R6: With bit 25 = 1, `pad_oe` is 0 whenever the value presented on `pad_out` after inversion is 1. A value of 0 keeps the selected output enable.
- R7: With bit 18 = 0, `per_din` is 0, and the wake compare sees a level of 0 regardless of `pad_in`.
- R8: `pad_pu`, `pad_pd`, `pad_ie`, `pad_hys` and `pad_drv` follow bits 17, 16, 18, 19 and 20.
- R9: With bit 18 = 1, a change on `pad_in` reaches `per_din` after exactly two clock edges.
- R10: With bit 27 = 1, `wake_req` is 1 in the cycle after the synchronized, gated pad level equals bit 28. With bit 27 = 0, `wake_req` is 0.
- R11: The wake status (bit 13) sets together with `wake_req` and stays set after the match ends. It clears one edge after `wake_clr`, with the clear taking priority over a simultaneous match. It also clears one edge after bit 27 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, including wake status |
| wake_clr | input | 1 | Clears the sticky wake status |
| per_dout | input | 63 | Peripheral output data, bit k-1 for function k |
| per_oe | input | 63 | Peripheral output enables, bit k-1 for function k |
| per_din | output | 1 | Pad input as seen by the peripherals |
| pad_in | input | 1 | Asynchronous level from the pad |
| pad_out | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad output driver enable |
| pad_pu | output | 1 | Pull-up control |
| pad_pd | output | 1 | Pull-down control |
| pad_ie | output | 1 | Input buffer enable |
| pad_hys | output | 1 | Hysteresis control |
| pad_drv | output | 1 | Drive-strength control |
| wake_req | output | 1 | Registered wake request |

## Verification
The output path is purely combinational from the register, so a wrong stored configuration field shows at `pad_out` or `pad_oe` in the same cycle it is loaded. A wrong pad-driver decision shows the same way, as soon as the offending peripheral pattern is applied. Faults in the synchronizer or the wake state are visible only through timing: a missing or extra stage moves the `per_din` and `wake_req` transitions by one edge. A broken sticky flag shows in bit 13 one edge after the match ends or after a clear. The bench therefore samples each of these at the exact edge count on both sides of every transition.

// File: rtl/iopad_pkg.sv
package iopad_pkg;

  localparam int unsigned CFG_W   = 32;
  localparam int unsigned SEL_W   = 6;
  localparam int unsigned SEL_LSB = 0;

  // bit positions software relies on
  localparam int unsigned B_WCMP = 28;
  localparam int unsigned B_WUEN = 27;
  localparam int unsigned B_INV  = 26;
  localparam int unsigned B_OD   = 25;
  localparam int unsigned B_DRV  = 20;
  localparam int unsigned B_HYS  = 19;
  localparam int unsigned B_IE   = 18;
  localparam int unsigned B_PU   = 17;
  localparam int unsigned B_PD   = 16;
  localparam int unsigned B_WSTS = 13;
  localparam int unsigned B_CONN = 7;

  typedef struct packed {
    logic             wcmp;
    logic             wuen;
    logic             inv;
    logic             od;
    logic             drv;
    logic             hys;
    logic             ie;
    logic             pu;
    logic             pd;
    logic             conn;
    logic [SEL_W-1:0] sel;
  } pad_cfg_t;

  function automatic pad_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    pad_cfg_t c;
    c.wcmp = w[B_WCMP];
    c.wuen = w[B_WUEN];
    c.inv  = w[B_INV];
    c.od   = w[B_OD];
    c.drv  = w[B_DRV];
    c.hys  = w[B_HYS];
    c.ie   = w[B_IE];
    c.pu   = w[B_PU];
    c.pd   = w[B_PD];
    c.conn = w[B_CONN];
    c.sel  = w[SEL_LSB +: SEL_W];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input pad_cfg_t c, input logic sts);
    logic [CFG_W-1:0] w;
    w                   = '0;
    w[B_WCMP]           = c.wcmp;
    w[B_WUEN]           = c.wuen;
    w[B_INV]            = c.inv;
    w[B_OD]             = c.od;
    w[B_DRV]            = c.drv;
    w[B_HYS]            = c.hys;
    w[B_IE]             = c.ie;
    w[B_PU]             = c.pu;
    w[B_PD]             = c.pd;
    w[B_WSTS]           = sts;
    w[B_CONN]           = c.conn;
    w[SEL_LSB +: SEL_W] = c.sel;
    return w;
  endfunction

  // driver enable after open-drain release of a high level
  function automatic logic drive_enable(input logic oe, input logic val, input logic od);
    return oe & ~(od & val);
  endfunction

  // level presented to the wake comparator
  function automatic logic wake_match(input logic lvl, input logic cmp, input logic en);
    return en & (lvl == cmp);
  endfunction

endpackage

// File: rtl/iopad_cfg_reg.sv
module iopad_cfg_reg
  import iopad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             sts,
  output pad_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);

  pad_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= cfg_unpack(wdata);
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_pack(cfg_q, sts);

endmodule

// File: rtl/iopad_func_mux.sv
module iopad_func_mux
  import iopad_pkg::*;
#(
  parameter int unsigned NUM_FUNC = 63
) (
  input  logic [SEL_W-1:0]    sel,
  input  logic                conn,
  input  logic [NUM_FUNC-1:0] dout,
  input  logic [NUM_FUNC-1:0] oe,
  output logic                live,
  output logic                mux_dat,
  output logic                mux_oe
);

  logic [NUM_FUNC-1:0] hit;

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_dec
    assign hit[i] = conn && (sel == SEL_W'(i + 1));
  end

  always_comb begin
    live    = |hit;
    mux_dat = |(hit & dout);
    mux_oe  = |(hit & oe);
  end

endmodule

// File: rtl/iopad_sync.sv
module iopad_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/iopad_wake.sv
module iopad_wake
  import iopad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic wuen,
  input  logic wcmp,
  input  logic clr,
  output logic hit,
  output logic req,
  output logic sts
);

  logic sts_nxt;

  assign hit     = wake_match(lvl, wcmp, wuen);
  assign sts_nxt = wuen & ~clr & (sts | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      sts <= 1'b0;
    end else begin
      req <= hit;
      sts <= sts_nxt;
    end
  end

endmodule

// File: rtl/iopad_cell.sv
module iopad_cell
  import iopad_pkg::*;
#(
  parameter int unsigned NUM_FUNC    = 63,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                wake_clr,
  input  logic [NUM_FUNC-1:0] per_dout,
  input  logic [NUM_FUNC-1:0] per_oe,
  output logic                per_din,
  input  logic                pad_in,
  output logic                pad_out,
  output logic                pad_oe,
  output logic                pad_pu,
  output logic                pad_pd,
  output logic                pad_ie,
  output logic                pad_hys,
  output logic                pad_drv,
  output logic                wake_req
);

  pad_cfg_t cfg_w;
  logic     sts_w;
  logic     live_w, mux_dat_w, mux_oe_w;
  logic     pad_sync_w, lvl_w, wake_hit_w;

  iopad_cfg_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .sts   (sts_w),
    .cfg   (cfg_w),
    .rdata (cfg_rdata)
  );

  iopad_func_mux #(.NUM_FUNC(NUM_FUNC)) u_mux (
    .sel     (cfg_w.sel),
    .conn    (cfg_w.conn),
    .dout    (per_dout),
    .oe      (per_oe),
    .live    (live_w),
    .mux_dat (mux_dat_w),
    .mux_oe  (mux_oe_w)
  );

  // output path: invert only a connected function, then open-drain release
  always_comb begin
    pad_out = live_w & (mux_dat_w ^ cfg_w.inv);
    pad_oe  = drive_enable(mux_oe_w, pad_out, cfg_w.od);
  end

  iopad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync_w)
  );

  // input path: gate first, invert only for the peripherals
  assign lvl_w   = cfg_w.ie & pad_sync_w;
  assign per_din = cfg_w.ie & (pad_sync_w ^ cfg_w.inv);

  iopad_wake u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl_w),
    .wuen  (cfg_w.wuen),
    .wcmp  (cfg_w.wcmp),
    .clr   (wake_clr),
    .hit   (wake_hit_w),
    .req   (wake_req),
    .sts   (sts_w)
  );

  assign pad_pu  = cfg_w.pu;
  assign pad_pd  = cfg_w.pd;
  assign pad_ie  = cfg_w.ie;
  assign pad_hys = cfg_w.hys;
  assign pad_drv = cfg_w.drv;

endmodule

// File: rtl/iopad_cell_chk.sv
module iopad_cell_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_rdata,
  input logic        wake_clr,
  input logic        per_din,
  input logic        pad_out,
  input logic        pad_oe,
  input logic        pad_sync,
  input logic        wake_hit,
  input logic        wake_req
);

  localparam logic [31:0] RSV_MASK = ~32'h1E1F20BF;

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & RSV_MASK) == 32'h0);

  assert_sel_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[5:0] == 6'd0) |-> (!pad_oe && !pad_out));

  assert_disconnect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |-> (!pad_oe && !pad_out));

  assert_od_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[25] && pad_out) |-> !pad_oe);

  assert_ie_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[18] |-> !per_din);

  assert_req_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[27] && ((pad_sync & cfg_rdata[18]) == cfg_rdata[28])) |=> wake_req);

  assert_req_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[27] |=> !wake_req);

  assert_sts_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && !wake_clr) |=> cfg_rdata[13]);

  assert_sts_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_clr |=> !cfg_rdata[13]);

  assert_sts_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[13] && cfg_rdata[27] && !wake_clr) |=> cfg_rdata[13]);

endmodule

bind iopad_cell iopad_cell_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .wake_clr  (wake_clr),
  .per_din   (per_din),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_sync  (pad_sync_w),
  .wake_hit  (wake_hit_w),
  .wake_req  (wake_req)
);

// File: tb/iopad_cell_tb.sv
`timescale 1ns/1ps
module iopad_cell_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        wake_clr = 1'b0;
  logic [62:0] per_dout = '0;
  logic [62:0] per_oe = '0;
  logic        per_din, pad_in = 1'b0;
  logic        pad_out, pad_oe, pad_pu, pad_pd, pad_ie, pad_hys, pad_drv, wake_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  iopad_cell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wake_clr(wake_clr), .per_dout(per_dout),
    .per_oe(per_oe), .per_din(per_din), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie),
    .pad_hys(pad_hys), .pad_drv(pad_drv), .wake_req(wake_req)
  );

  // {cfg, per_dout, per_oe, expected pad_out, expected pad_oe}
  localparam int NV = 10;
  localparam logic [159:0] VEC [NV] = '{
    {32'h0000_0085, 63'h10, 63'h10, 1'b1, 1'b1},                 // R3 sel 5
    {32'h0000_0085, ~63'h10, {63{1'b1}}, 1'b0, 1'b1},            // R3 sel 5 low
    {32'h0000_0005, 63'h10, 63'h10, 1'b0, 1'b0},                 // R4 disconnected
    {32'h0000_0080, {63{1'b1}}, {63{1'b1}}, 1'b0, 1'b0},         // R3 select 0
    {32'h0000_00BF, 63'h4000_0000_0000_0000, 63'h4000_0000_0000_0000, 1'b1, 1'b1}, // R3 sel 63
    {32'h0400_0081, 63'h0, 63'h1, 1'b1, 1'b1},                   // R5 inverted
    {32'h0200_0081, 63'h1, 63'h1, 1'b1, 1'b0},                   // R6 release high
    {32'h0200_0081, 63'h0, 63'h1, 1'b0, 1'b1},                   // R6 drive low
    {32'h0600_0081, 63'h1, 63'h1, 1'b0, 1'b1},                   // R5 R6 inv low
    {32'h0600_0081, 63'h0, 63'h1, 1'b1, 1'b0}                    // R5 R6 inv high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1 cfg", cfg_rdata, 32'h0);
    check("R1 pad", {30'b0, pad_out, pad_oe}, 32'h0);
    check("R1 din/wake", {30'b0, per_din, wake_req}, 32'h0);
    rst_n = 1'b1;
    step(1);

    // output path table
    for (int v = 0; v < NV; v++) begin
      per_dout = VEC[v][127:65];
      per_oe   = VEC[v][64:2];
      wr(VEC[v][159:128]);
      check($sformatf("R3-6 vec%0d out", v), {31'b0, pad_out}, {31'b0, VEC[v][1]});
      check($sformatf("R3-6 vec%0d oe", v),  {31'b0, pad_oe},  {31'b0, VEC[v][0]});
    end
    per_dout = '0;
    per_oe   = '0;

    // R2 writable mask, R8 control outputs
    wr(32'hFFFF_FFFF);
    check("R2 mask", cfg_rdata, 32'h1E1F_00BF);
    check("R8 all on", {27'b0, pad_pu, pad_pd, pad_ie, pad_hys, pad_drv}, 32'h1F);
    wr(32'h0002_0000);
    check("R8 pull-up only", {27'b0, pad_pu, pad_pd, pad_ie, pad_hys, pad_drv}, 32'h10);
    wr(32'h0011_2000);
    check("R2 status not writable", cfg_rdata, 32'h0011_0000);
    check("R8 pd+drv", {27'b0, pad_pu, pad_pd, pad_ie, pad_hys, pad_drv}, 32'h09);

    // R9 two-edge input latency
    wr(32'h0004_0000);
    pad_in = 1'b1;
    step(1);
    check("R9 one edge", {31'b0, per_din}, 32'h0);
    step(1);
    check("R9 two edges", {31'b0, per_din}, 32'h1);
    wr(32'h0404_0000);
    check("R5 input inverted", {31'b0, per_din}, 32'h0);
    wr(32'h0400_0000);
    check("R7 input disabled", {31'b0, per_din}, 32'h0);

    // R10 R11 wake on high
    wr(32'h1804_0000);
    check("R10 not yet", {31'b0, wake_req}, 32'h0);
    step(1);
    check("R10 request", {31'b0, wake_req}, 32'h1);
    check("R11 status set", {31'b0, cfg_rdata[13]}, 32'h1);
    pad_in = 1'b0;
    step(2);
    check("R10 held through sync", {31'b0, wake_req}, 32'h1);
    step(1);
    check("R10 dropped", {31'b0, wake_req}, 32'h0);
    check("R11 sticky", {31'b0, cfg_rdata[13]}, 32'h1);
    wake_clr = 1'b1;
    step(1);
    wake_clr = 1'b0;
    check("R11 cleared", {31'b0, cfg_rdata[13]}, 32'h0);

    // wake on low, clear against live match
    wr(32'h0804_0000);
    step(1);
    check("R10 low match", {31'b0, wake_req}, 32'h1);
    wake_clr = 1'b1;
    step(1);
    wake_clr = 1'b0;
    check("R11 clear wins", {31'b0, cfg_rdata[13]}, 32'h0);
    check("R10 req unaffected", {31'b0, wake_req}, 32'h1);
    step(1);
    check("R11 re-set", {31'b0, cfg_rdata[13]}, 32'h1);
    wr(32'h0004_0000);
    step(1);
    check("R11 disable clears", {31'b0, cfg_rdata[13]}, 32'h0);
    check("R10 disabled", {31'b0, wake_req}, 32'h0);

    // R7 wake compare sees 0 while input disabled
    pad_in = 1'b1;
    step(3);
    wr(32'h0800_0000);
    step(1);
    check("R7 gated wake", {31'b0, wake_req}, 32'h1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule